// File: doc/BRIEF.md
# Dual-Port Busy Contention Arbiter

This block sits between two independent memory ports and a shared storage array. On every clock it compares the registered selection of both ports. When both are selected and point at the same location, it records which port got there first. The port that arrived later sees an active-low busy flag, and its write strobe toward the array is withheld for as long as that flag is set. The array itself, any tri-state I/O and all analog timing are outside the block.

A mode input chooses between two roles. As master, the block runs its own arbitration and drives both busy lines. As slave, it ignores its own result, holds its busy outputs released, and gates writes with busy lines supplied by a master. Several blocks can then share one arbitration decision when they are placed side by side to form a wider word.

Timing: port inputs are sampled on one rising edge. The busy outputs and write strobes that belong to that request are valid after the next rising edge.

Top module: `dp_contention_arb`

## Requirements
- R1: While reset is asserted, and right after it is released, both busy outputs are high (released), both write strobes are low, and no port holds ownership.
- R2: No busy is asserted unless both selects are high and both addresses are equal in the registered sample.
- R3: If one port has held a selected address for at least one cycle and the other port then moves onto that address, the port that moved is flagged busy (its busy output goes low) and the first port stays free.
- R4: Asserting a port's select onto an address the other port already selects flags the newly selecting port busy.
- R5: If both ports start matching in the same sampled cycle, the left port wins and only the right busy is asserted.
- R6: In master mode the two busy outputs are never low at the same time.
- R7: Busy is released once the addresses differ or either select drops. While the match persists, the owner does not change.
- R8: In master mode each write strobe equals that port's write request, delayed by two edges, ANDed with not-busy. The busy input pins have no effect.
- R9: In slave mode (mode input low) both busy outputs are held high. Each write strobe equals the delayed write request ANDed with the port's active-low busy input pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_mode | input | 1 | 1 = master (drives busy), 0 = slave (uses busy inputs) |
| l_sel | input | 1 | Left port select, active high |
| l_addr | input | ADDR_W | Left port address |
| l_wr_req | input | 1 | Left port write request |
| r_sel | input | 1 | Right port select, active high |
| r_addr | input | ADDR_W | Right port address |
| r_wr_req | input | 1 | Right port write request |
| l_busy_in_n | input | 1 | Left busy from a master, active low (slave mode) |
| r_busy_in_n | input | 1 | Right busy from a master, active low (slave mode) |
| l_busy_n | output | 1 | Left busy, active low |
| r_busy_n | output | 1 | Right busy, active low |
| l_wr_en | output | 1 | Gated left write strobe |
| r_wr_en | output | 1 | Gated right write strobe |

## Verification
The hardest case to reach is arrival order. Which port loses depends on whether each port's selection was already stable one cycle before the match, so a single input pattern cannot set it up. The bench therefore builds every case as a short sequence: both ports idle, then one port settles, then the other. It sweeps left-first, right-first and same-cycle arrival across all address pairs and select combinations of a 3-bit configuration. A directed sequence then moves a loser away and back and drops selects to check release and re-arbitration.

// File: rtl/dpa_pkg.sv
package dpa_pkg;
  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_t;

  localparam int NPORTS = 2;
  localparam int PL     = 0;
  localparam int PR     = 1;
endpackage

// File: rtl/dpa_port_stage.sv
module dpa_port_stage #(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_req,
  output logic              sel_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic              fresh,
  output logic              wr_req_d2
);
  logic              sel_q2;
  logic [ADDR_W-1:0] addr_q2;
  logic              wr_q;
  logic              wr_q2;
  logic              addr_ld;
  logic              hist_ld;

  // clock enables: capture address only for a selected port
  assign addr_ld = sel;
  assign hist_ld = sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= 1'b0;
      sel_q2 <= 1'b0;
      wr_q   <= 1'b0;
      wr_q2  <= 1'b0;
    end else begin
      sel_q  <= sel;
      sel_q2 <= sel_q;
      wr_q   <= wr_req;
      wr_q2  <= wr_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (addr_ld) begin
      addr_q <= addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q2 <= '0;
    end else if (hist_ld) begin
      addr_q2 <= addr_q;
    end
  end

  // selection became valid or changed in the latest sample
  always_comb begin
    fresh = sel_q && (!sel_q2 || (addr_q != addr_q2));
  end

  assign wr_req_d2 = wr_q2;
endmodule

// File: rtl/dpa_arb_core.sv
module dpa_arb_core
  import dpa_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_sel,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              l_fresh,
  input  logic              r_sel,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic              r_fresh,
  output logic              l_lose,
  output logic              r_lose
);
  owner_t owner_q;
  owner_t owner_d;
  logic   match;

  assign match = l_sel && r_sel && (l_addr == r_addr);

  always_comb begin
    owner_d = owner_q;
    if (!match) begin
      owner_d = OWN_NONE;
    end else if (owner_q == OWN_NONE) begin
      // later arrival loses; same-cycle arrival goes to the left port
      if (l_fresh && !r_fresh) owner_d = OWN_RIGHT;
      else                     owner_d = OWN_LEFT;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) owner_q <= OWN_NONE;
    else        owner_q <= owner_d;
  end

  assign l_lose = (owner_q == OWN_RIGHT);
  assign r_lose = (owner_q == OWN_LEFT);

  AST_BUSY_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_q != OWN_NONE) |-> $past(match)); // R2

  AST_OWNER_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ((owner_q != OWN_NONE) && match) |=> (owner_q == $past(owner_q))); // R7

  AST_TIE_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
    ((owner_q == OWN_NONE) && match && l_fresh && r_fresh) |=> (owner_q == OWN_LEFT)); // R5

  AST_LATE_LOSES: assert property (@(posedge clk) disable iff (!rst_n)
    ((owner_q == OWN_NONE) && match && l_fresh && !r_fresh) |=> l_lose); // R3
endmodule

// File: rtl/dp_contention_arb.sv
module dp_contention_arb
  import dpa_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              master_mode,
  input  logic              l_sel,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              l_wr_req,
  input  logic              r_sel,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic              r_wr_req,
  input  logic              l_busy_in_n,
  input  logic              r_busy_in_n,
  output logic              l_busy_n,
  output logic              r_busy_n,
  output logic              l_wr_en,
  output logic              r_wr_en
);
  logic              sel_in   [NPORTS];
  logic [ADDR_W-1:0] addr_in  [NPORTS];
  logic              wr_in    [NPORTS];
  logic              bin_n    [NPORTS];
  logic              sel_q    [NPORTS];
  logic [ADDR_W-1:0] addr_q   [NPORTS];
  logic              fresh    [NPORTS];
  logic              wr_d2    [NPORTS];
  logic              lose     [NPORTS];
  logic              busy_eff [NPORTS];
  logic              busy_o_n [NPORTS];
  logic              wr_o     [NPORTS];

  assign sel_in[PL]  = l_sel;
  assign sel_in[PR]  = r_sel;
  assign addr_in[PL] = l_addr;
  assign addr_in[PR] = r_addr;
  assign wr_in[PL]   = l_wr_req;
  assign wr_in[PR]   = r_wr_req;
  assign bin_n[PL]   = l_busy_in_n;
  assign bin_n[PR]   = r_busy_in_n;

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    dpa_port_stage #(.ADDR_W(ADDR_W)) u_stage (
      .clk       (clk),
      .rst_n     (rst_n),
      .sel       (sel_in[p]),
      .addr      (addr_in[p]),
      .wr_req    (wr_in[p]),
      .sel_q     (sel_q[p]),
      .addr_q    (addr_q[p]),
      .fresh     (fresh[p]),
      .wr_req_d2 (wr_d2[p])
    );

    always_comb begin
      if (master_mode) begin
        busy_eff[p] = lose[p];
        busy_o_n[p] = !lose[p];
      end else begin
        busy_eff[p] = !bin_n[p];
        busy_o_n[p] = 1'b1;
      end
      wr_o[p] = wr_d2[p] && !busy_eff[p];
    end
  end

  dpa_arb_core #(.ADDR_W(ADDR_W)) u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .l_sel   (sel_q[PL]),
    .l_addr  (addr_q[PL]),
    .l_fresh (fresh[PL]),
    .r_sel   (sel_q[PR]),
    .r_addr  (addr_q[PR]),
    .r_fresh (fresh[PR]),
    .l_lose  (lose[PL]),
    .r_lose  (lose[PR])
  );

  assign l_busy_n = busy_o_n[PL];
  assign r_busy_n = busy_o_n[PR];
  assign l_wr_en  = wr_o[PL];
  assign r_wr_en  = wr_o[PR];

  AST_ONE_LOSER: assert property (@(posedge clk) disable iff (!rst_n)
    master_mode |-> (l_busy_n || r_busy_n)); // R6

  AST_NO_WRITE_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (master_mode && !l_busy_n) |-> !l_wr_en); // R8

  AST_SLAVE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (!master_mode && !r_busy_in_n) |-> !r_wr_en); // R9

  AST_SLAVE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !master_mode |-> (l_busy_n && r_busy_n)); // R9
endmodule

// File: tb/dp_contention_arb_test.sv
`timescale 1ns/1ps
module dp_contention_arb_test;
  localparam int AW = 3;
  localparam int NA = 1 << AW;

  logic          clk;
  logic          rst_n;
  logic          master_mode;
  logic          l_sel, r_sel, l_wr_req, r_wr_req;
  logic [AW-1:0] l_addr, r_addr;
  logic          l_busy_in_n, r_busy_in_n;
  logic          l_busy_n, r_busy_n, l_wr_en, r_wr_en;

  int checks;
  int errors;

  dp_contention_arb #(.ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .master_mode(master_mode),
    .l_sel(l_sel), .l_addr(l_addr), .l_wr_req(l_wr_req),
    .r_sel(r_sel), .r_addr(r_addr), .r_wr_req(r_wr_req),
    .l_busy_in_n(l_busy_in_n), .r_busy_in_n(r_busy_in_n),
    .l_busy_n(l_busy_n), .r_busy_n(r_busy_n),
    .l_wr_en(l_wr_en), .r_wr_en(r_wr_en)
  );

  initial clk = 1'b0;
  always #2.5 clk = !clk;

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // master-mode outputs with write requests held high
  task automatic chk_master(input string req, input logic exp_lb, input logic exp_rb);
    chk(req, "l_busy_n", l_busy_n, !exp_lb);
    chk(req, "r_busy_n", r_busy_n, !exp_rb);
    chk("R8", "l_wr_en", l_wr_en, !exp_lb);
    chk("R8", "r_wr_en", r_wr_en, !exp_rb);
    chk("R6", "not both busy", l_busy_n || r_busy_n, 1'b1);
  endtask

  initial begin : watchdog
    #1000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    checks = 0;
    errors = 0;
    rst_n = 1'b0;
    master_mode = 1'b1;
    l_sel = 1'b0; r_sel = 1'b0;
    l_addr = '0;  r_addr = '0;
    l_wr_req = 1'b1; r_wr_req = 1'b1;
    l_busy_in_n = 1'b1; r_busy_in_n = 1'b1;
    step(3);
    // R1: reset state
    chk("R1", "l_busy_n in reset", l_busy_n, 1'b1);
    chk("R1", "r_busy_n in reset", r_busy_n, 1'b1);
    chk("R1", "l_wr_en in reset", l_wr_en, 1'b0);
    chk("R1", "r_wr_en in reset", r_wr_en, 1'b0);
    rst_n = 1'b1;
    step(1);
    chk("R1", "l_busy_n after reset", l_busy_n, 1'b1);
    chk("R1", "r_busy_n after reset", r_busy_n, 1'b1);
    step(2);

    // sweep: order 0 = left first, 1 = right first, 2 = same cycle
    for (int la = 0; la < NA; la++) begin
      for (int ra = 0; ra < NA; ra++) begin
        for (int en = 0; en < 4; en++) begin
          for (int ord = 0; ord < 3; ord++) begin
            logic le, re, m, exp_lb, exp_rb;
            le = en[0];
            re = en[1];
            l_sel = 1'b0; r_sel = 1'b0;
            // busy input pins toggled to show they are ignored in master mode (R8)
            l_busy_in_n = la[0];
            r_busy_in_n = ra[1];
            step(3);
            chk("R7", "l_busy_n released when idle", l_busy_n, 1'b1);
            l_addr = la[AW-1:0];
            r_addr = ra[AW-1:0];
            if (ord == 0) begin
              l_sel = le; step(3); r_sel = re;
            end else if (ord == 1) begin
              r_sel = re; step(3); l_sel = le;
            end else begin
              l_sel = le; r_sel = re;
            end
            step(3);
            m = le && re && (la == ra);
            exp_lb = m && (ord == 1);
            exp_rb = m && (ord != 1);
            if (!m)            chk_master("R2", exp_lb, exp_rb);
            else if (ord == 0) chk_master("R3", exp_lb, exp_rb);
            else if (ord == 1) chk_master("R4", exp_lb, exp_rb);
            else               chk_master("R5", exp_lb, exp_rb);
          end
        end
      end
    end

    // directed: release and re-arbitration
    l_sel = 1'b0; r_sel = 1'b0; step(3);
    l_sel = 1'b1; l_addr = 3'd2; step(3);
    r_sel = 1'b1; r_addr = 3'd2; step(3);
    chk_master("R3", 1'b0, 1'b1);
    r_addr = 3'd3; step(3);
    chk_master("R7", 1'b0, 1'b0);
    r_addr = 3'd2; step(3);
    chk_master("R3", 1'b0, 1'b1);
    step(5);
    chk_master("R7", 1'b0, 1'b1);  // owner held while match persists
    l_sel = 1'b0; step(3);
    chk_master("R7", 1'b0, 1'b0);
    l_sel = 1'b1; step(3);
    chk_master("R4", 1'b1, 1'b0);

    // write request low: strobes stay low (R8)
    l_addr = 3'd5; step(3);
    l_wr_req = 1'b0; r_wr_req = 1'b0; step(1);
    chk("R8", "l_wr_en one edge after drop", l_wr_en, 1'b1);
    step(1);
    chk("R8", "l_wr_en low", l_wr_en, 1'b0);
    chk("R8", "r_wr_en low", r_wr_en, 1'b0);
    l_wr_req = 1'b1; r_wr_req = 1'b1; step(3);

    // slave mode with a live contention on the ports
    master_mode = 1'b0;
    l_addr = 3'd1; r_addr = 3'd1;
    l_sel = 1'b0; r_sel = 1'b0; step(3);
    l_sel = 1'b1; r_sel = 1'b1; step(3);
    for (int b = 0; b < 4; b++) begin
      l_busy_in_n = b[0];
      r_busy_in_n = b[1];
      step(1);
      chk("R9", "l_busy_n held high", l_busy_n, 1'b1);
      chk("R9", "r_busy_n held high", r_busy_n, 1'b1);
      chk("R9", "l_wr_en follows busy in", l_wr_en, b[0]);
      chk("R9", "r_wr_en follows busy in", r_wr_en, b[1]);
    end
    l_wr_req = 1'b0; l_busy_in_n = 1'b1; step(3);
    chk("R9", "l_wr_en needs request", l_wr_en, 1'b0);

    // back to master: the ongoing contention shows a single loser
    master_mode = 1'b1; step(1);
    chk("R6", "one loser after mode return", l_busy_n ^ r_busy_n, 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule